// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This unit watches a processor core for hardware events and keeps counts of them. It holds a cycle counter and a parameterised number of event counters (four by default). Each event counter is set up with an event code that picks one of twelve single-cycle strobe lines from the core. The counter then advances on every clock in which that line is high. The cycle counter advances on every clock, or once per 64 clocks when its prescale mode is on.

Software reaches the unit through a synchronous register port with separate write and read strobes. A read returns its data on the clock after the request. A control register holds a global run bit, a prescale bit, and two self-clearing clear commands. A set-only enable mask chooses which counters may run. An overflow flag register is cleared by writing ones to it. A select register names the event counter that the event-code and count windows reach. The cycle count is read through its own address.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset every register reads zero. A read request is answered on `reg_rdata` on the clock that follows it. Addresses: 0 control, 1 enable mask, 2 overflow flags, 3 select, 4 event code window, 5 event count window, 6 cycle count.
- R2: While control bit 0 (run) is clear, no counter advances, whatever the strobes and the enable mask are.
- R3: While run is set, enable bit 31 is set and control bit 3 is clear, the cycle counter advances by one on every clock. Address 6 returns its value.
- R4: While control bit 3 is set, the cycle counter advances once per 64 counted clocks. Bit 3 reads back as written.
- R5: Writing control with bit 2 set clears the cycle counter and its prescaler. Bits 1 and 2 always read back as 0.
- R6: Writing control with bit 1 set clears every event counter.
- R7: Writing the enable mask sets each bit written as 1 and leaves every other bit unchanged. Bits 0..3 belong to the event counters and bit 31 to the cycle counter. A read returns the mask.
- R8: The select register holds an index. Addresses 4 and 5 then read and write the event code and the count of the event counter with that index. A count write loads the counter.
- R9: While the select index is 4 or more, reads of addresses 4 and 5 return zero and writes to them change no counter. The select register reads back as written.
- R10: While run and its enable bit are set, an event counter advances on each clock in which the strobe bit equal to its event code is high. Strobe bit 0 is software increment, 1 instruction cache refill, 2 instruction TLB refill, 3 data cache refill, 4 data cache access, 5 data TLB refill, 6 memory read, 7 memory write, 8 instruction executed, 9 exception taken, 10 exception return, 11 context ID write. A code of 12 or more counts nothing.
- R11: When an event counter wraps from all ones to zero, overflow flag bit i (the counter's index) sets.
- R12: Writing a 1 to an overflow flag bit clears that flag. If the counter wraps in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| evt_strobe | input | 12 | One strobe per event code, bit index equals code |

## Verification
Two things can land on an overflow flag in the same clock: a counter wrapping from all ones, which sets the flag, and a software write of 1, which clears it. The bench preloads counter 0 with all ones. It then drives the overflow clear write and the selected strobe on the same edge. A later read must show the flag still set and the counter at zero, and a second clear with no wrap must then drop the flag.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int NUM_EVT = 12;
  localparam int CODE_W  = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_ENABLE = 3'd1,
    A_OVF    = 3'd2,
    A_SELECT = 3'd3,
    A_CODE   = 3'd4,
    A_COUNT  = 3'd5,
    A_CYCLE  = 3'd6
  } reg_addr_e;

  // control bit positions
  localparam int C_RUN    = 0;
  localparam int C_EVCLR  = 1;
  localparam int C_CYCCLR = 2;
  localparam int C_DIV    = 3;
endpackage

// File: rtl/pmu_event_ctr.sv
module pmu_event_ctr #(
  parameter int CNT_W   = 32,
  parameter int NUM_EVT = 12,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               run_i,
  input  logic               cnt_wr_i,
  input  logic               code_wr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               wrap_o
);
  logic [CNT_W-1:0]  cnt_q;
  logic [CODE_W-1:0] code_q;
  logic              hit;
  logic              inc;

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < NUM_EVT; k++)
      if (code_q == CODE_W'(k)) hit = evt_i[k];
  end

  assign inc    = run_i && hit;
  assign wrap_o = inc && (&cnt_q) && !clr_i && !cnt_wr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      if (code_wr_i) code_q <= wdata_i[CODE_W-1:0];
      if (clr_i)         cnt_q <= '0;
      else if (cnt_wr_i) cnt_q <= wdata_i;
      else if (inc)      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign code_o = code_q;

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_i && !clr_i && !cnt_wr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmu_cycle_ctr.sv
module pmu_cycle_ctr #(
  parameter int CNT_W = 32,
  parameter int PS_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             div_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [PS_W-1:0]  pre_q;
  logic             tick;

  assign tick   = run_i && (!div_i || (&pre_q));
  assign wrap_o = tick && (&cnt_q) && !clr_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (run_i && div_i) pre_q <= pre_q + 1'b1;
      if (tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R3
  every_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && !div_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R4
  prescale_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && div_i && !(&pre_q) && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
  import pmu_pkg::*;
#(
  parameter int NUM_CTR = 4,
  parameter int PS_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_EVT-1:0] evt_strobe
);
  localparam int IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;
  localparam int CYC_BIT = DATA_W - 1;

  logic               run_q, div_q;
  logic [NUM_CTR-1:0] en_ev_q, ovf_ev_q;
  logic               en_cyc_q, ovf_cyc_q;
  logic [CODE_W-1:0]  sel_q;
  logic               sel_ok;
  logic [IDX_W-1:0]   sel_idx;

  logic wr_ctrl, wr_en, wr_ovf, wr_sel, wr_code, wr_cnt;
  logic clr_ev, clr_cyc;

  logic [DATA_W-1:0]  ev_cnt  [NUM_CTR];
  logic [CODE_W-1:0]  ev_code [NUM_CTR];
  logic [NUM_CTR-1:0] ev_wrap;
  logic [DATA_W-1:0]  cyc_cnt;
  logic               cyc_wrap;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_en   = reg_wr && (reg_addr == A_ENABLE);
  assign wr_ovf  = reg_wr && (reg_addr == A_OVF);
  assign wr_sel  = reg_wr && (reg_addr == A_SELECT);
  assign wr_code = reg_wr && (reg_addr == A_CODE);
  assign wr_cnt  = reg_wr && (reg_addr == A_COUNT);
  assign clr_ev  = wr_ctrl && reg_wdata[C_EVCLR];
  assign clr_cyc = wr_ctrl && reg_wdata[C_CYCCLR];
  assign sel_ok  = (sel_q < CODE_W'(NUM_CTR));
  assign sel_idx = sel_q[IDX_W-1:0];

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ev
    logic hit_sel;
    assign hit_sel = sel_ok && (sel_q == CODE_W'(i));
    pmu_event_ctr #(.CNT_W(DATA_W), .NUM_EVT(NUM_EVT), .CODE_W(CODE_W)) u_ctr (
      .clk(clk), .rst(rst), .clr_i(clr_ev),
      .run_i(run_q && en_ev_q[i]),
      .cnt_wr_i(wr_cnt && hit_sel), .code_wr_i(wr_code && hit_sel),
      .wdata_i(reg_wdata), .evt_i(evt_strobe),
      .cnt_o(ev_cnt[i]), .code_o(ev_code[i]), .wrap_o(ev_wrap[i])
    );
  end

  pmu_cycle_ctr #(.CNT_W(DATA_W), .PS_W(PS_W)) u_cyc (
    .clk(clk), .rst(rst), .clr_i(clr_cyc), .run_i(run_q && en_cyc_q),
    .div_i(div_q), .cnt_o(cyc_cnt), .wrap_o(cyc_wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      div_q     <= 1'b0;
      en_ev_q   <= '0;
      en_cyc_q  <= 1'b0;
      ovf_ev_q  <= '0;
      ovf_cyc_q <= 1'b0;
      sel_q     <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= reg_wdata[C_RUN];
        div_q <= reg_wdata[C_DIV];
      end
      if (wr_en) begin
        en_ev_q  <= en_ev_q | reg_wdata[NUM_CTR-1:0];
        en_cyc_q <= en_cyc_q | reg_wdata[CYC_BIT];
      end
      if (wr_sel) sel_q <= reg_wdata[CODE_W-1:0];
      for (int i = 0; i < NUM_CTR; i++) begin
        if (ev_wrap[i])                    ovf_ev_q[i] <= 1'b1;
        else if (wr_ovf && reg_wdata[i])   ovf_ev_q[i] <= 1'b0;
      end
      if (cyc_wrap)                        ovf_cyc_q <= 1'b1;
      else if (wr_ovf && reg_wdata[CYC_BIT]) ovf_cyc_q <= 1'b0;
    end
  end

  function automatic logic [DATA_W-1:0] pack_mask(logic [NUM_CTR-1:0] ev, logic cyc);
    logic [DATA_W-1:0] m;
    m = '0;
    m[NUM_CTR-1:0] = ev;
    m[CYC_BIT] = cyc;
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_CTRL: begin
          reg_rdata <= '0;
          reg_rdata[C_RUN] <= run_q;
          reg_rdata[C_DIV] <= div_q;
        end
        A_ENABLE: reg_rdata <= pack_mask(en_ev_q, en_cyc_q);
        A_OVF:    reg_rdata <= pack_mask(ovf_ev_q, ovf_cyc_q);
        A_SELECT: reg_rdata <= DATA_W'(sel_q);
        A_CODE:   reg_rdata <= sel_ok ? DATA_W'(ev_code[sel_idx]) : '0;
        A_COUNT:  reg_rdata <= sel_ok ? ev_cnt[sel_idx] : '0;
        A_CYCLE:  reg_rdata <= cyc_cnt;
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R5
  cyc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_cyc |=> (cyc_cnt == '0));

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_chk
    // R6
    ev_clear_chk: assert property (@(posedge clk) disable iff (rst)
      clr_ev |=> (ev_cnt[i] == '0));
    // R11
    wrap_flag_chk: assert property (@(posedge clk) disable iff (rst)
      ev_wrap[i] |=> (ovf_ev_q[i] && ev_cnt[i] == '0));
    // R12
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ovf && reg_wdata[i] && !ev_wrap[i]) |=> !ovf_ev_q[i]);
  end
endmodule

// File: tb/pmu_counter_unit_bench.sv
module pmu_counter_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [11:0] evt_strobe = '0;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;
  logic rd_q = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pmu_counter_unit u_pmu_counter_unit (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_strobe(evt_strobe)
  );

  always @(posedge clk) rd_q <= reg_rd;

  // monitor: compare each answered read with the scoreboard head
  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      nchk++;
      if (reg_rdata !== e) begin
        nfail++;
        $display("FAIL %s: got %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [11:0] m, input int n);
    evt_strobe = m;
    repeat (n) @(negedge clk);
    evt_strobe = '0;
  endtask

  task automatic rd_ctr(input int idx, input logic [31:0] e, input string t);
    wr(3'd3, idx);
    rd(3'd5, e, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, 32'h0, "R1 ctrl");
    rd(3'd1, 32'h0, "R1 enable");
    rd(3'd2, 32'h0, "R1 ovf");
    rd(3'd3, 32'h0, "R1 select");
    rd(3'd6, 32'h0, "R1 cycle");
    rd(3'd5, 32'h0, "R1 count");
    // R7 set-only enable mask
    wr(3'd1, 32'h0000_0005);
    rd(3'd1, 32'h0000_0005, "R7 mask a");
    wr(3'd1, 32'h8000_0000);
    rd(3'd1, 32'h8000_0005, "R7 mask b");
    wr(3'd1, 32'h0000_000A);
    rd(3'd1, 32'h8000_000F, "R7 mask c");
    // R2 no counting without run
    wr(3'd3, 0); wr(3'd4, 8);
    pulse(12'h100, 5);
    idle(3);
    rd(3'd5, 32'h0, "R2 event held");
    rd(3'd6, 32'h0, "R2 cycle held");
    // R3 cycle counter every clock
    wr(3'd0, 32'h5);
    rd(3'd0, 32'h1, "R5 clear bits read 0");
    idle(18);
    wr(3'd0, 32'h0);
    rd(3'd6, 32'd20, "R3 cycle count");
    // R5 clear cycle
    wr(3'd0, 32'h4);
    rd(3'd6, 32'd0, "R5 cycle cleared");
    // R4 prescale
    wr(3'd0, 32'hD);
    idle(129);
    wr(3'd0, 32'h8);
    rd(3'd6, 32'd2, "R4 divided count");
    rd(3'd0, 32'h8, "R4 div readback");
    wr(3'd0, 32'h0);
    // R8/R10 event selection
    wr(3'd3, 0); wr(3'd4, 32'h01);
    wr(3'd3, 1); wr(3'd4, 32'h06);
    wr(3'd3, 2); wr(3'd4, 32'h07);
    wr(3'd3, 3); wr(3'd4, 32'h0B);
    wr(3'd3, 2);
    rd(3'd4, 32'h07, "R8 code readback");
    wr(3'd0, 32'h1);
    pulse(12'h002, 3);
    pulse(12'h040, 4);
    pulse(12'h0C0, 2);
    pulse(12'h800, 5);
    pulse(12'h100, 7);
    wr(3'd0, 32'h0);
    rd_ctr(0, 32'd3, "R10 ctr0");
    rd_ctr(1, 32'd6, "R10 ctr1");
    rd_ctr(2, 32'd2, "R10 ctr2");
    rd_ctr(3, 32'd5, "R10 ctr3");
    // R9 out-of-range select
    wr(3'd3, 5);
    rd(3'd3, 32'd5, "R9 select readback");
    rd(3'd5, 32'h0, "R9 count reads zero");
    rd(3'd4, 32'h0, "R9 code reads zero");
    wr(3'd5, 32'h55); wr(3'd4, 32'h3);
    rd_ctr(0, 32'd3, "R9 count untouched");
    rd(3'd4, 32'h01, "R9 code untouched");
    // R8 count load
    wr(3'd3, 3); wr(3'd5, 32'h1234);
    rd(3'd5, 32'h1234, "R8 count load");
    // R6 clear events
    wr(3'd0, 32'h2);
    rd_ctr(0, 32'd0, "R6 ctr0 cleared");
    rd_ctr(3, 32'd0, "R6 ctr3 cleared");
    // R11 wrap
    wr(3'd3, 0); wr(3'd5, 32'hFFFF_FFFE);
    wr(3'd0, 32'h1);
    pulse(12'h002, 2);
    wr(3'd0, 32'h0);
    rd(3'd5, 32'h0, "R11 wrapped to zero");
    rd(3'd2, 32'h1, "R11 flag set");
    // R12 clear, then clear racing a wrap
    wr(3'd2, 32'h1);
    rd(3'd2, 32'h0, "R12 flag cleared");
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd0, 32'h1);
    evt_strobe = 12'h002;
    wr(3'd2, 32'h1);
    evt_strobe = '0;
    wr(3'd0, 32'h0);
    rd(3'd2, 32'h1, "R12 wrap beats clear");
    rd(3'd5, 32'h0, "R12 counter zero");
    wr(3'd2, 32'h1);
    rd(3'd2, 32'h0, "R12 later clear");
    idle(4);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule